// File: doc/BRIEF.md
# Dual-Link Pixel Steering Stage

This block sits between a parallel pixel input and two lane serializers. Two configuration pins pick one of four ways of handing pixels to the two output channels. In single mode only channel 1 carries pixels. In split mode consecutive pixels alternate between the channels, so each channel runs at half the pixel rate. In broadcast mode both channels carry the same pixel. In double-edge mode a pixel is taken on each clock edge and the two edges feed the two channels. The serializers that follow are outside this block.

In split mode the pixel pairing is locked to the rising edge of the data-enable (DE) input. The first active pixel of every line goes to channel 1. If a line ends with an odd number of pixels, the leftover pixel is still delivered and an error pulse is raised. Configuration pin changes are taken up only while DE is low, so a mode switch can never cut a line in two.

Top module: `dual_link_pixel_steer`

## Requirements
- R1: While reset is asserted and until the first clock edge after it is released, `word_valid` and `de_err` are 0 and `ch2_hiz` is 1. Reset selects single mode.
- R2: In single mode (`mode_single`=1, `ddr_en`=0), every clock edge loads the sampled pixel into `ch1_word` and drives `word_valid` high, whatever the level of DE.
- R3: In split mode (`mode_single`=0, `ddr_en`=0), the first pixel sampled with DE high after DE rises is held. The pixel sampled on the next edge goes to `ch2_word`, and the held pixel goes to `ch1_word` on that same edge, with one shared `word_valid` pulse. `word_valid` stays low on every other edge.
- R4: In split mode, if DE is sampled low directly after an odd number of active pixels, the next edge presents the unpaired pixel on `ch1_word` with `word_valid` high. On that edge `ch2_word` keeps its previous value and `de_err` pulses high for one cycle.
- R5: In broadcast mode (`mode_single`=1, `ddr_en`=1), every edge loads the same sampled pixel into both `ch1_word` and `ch2_word`, with `word_valid` high.
- R6: In double-edge mode (`mode_single`=0, `ddr_en`=1), every rising edge presents a pair with `word_valid` high. `ch1_word` is the pixel sampled on the previous rising edge, and `ch2_word` is the pixel sampled on the falling edge between the two rising edges.
- R7: The configuration pins are taken up only on edges where DE is sampled low. A change while DE is high has no effect until DE is next sampled low. Taking up a new mode clears the split-mode pairing state.
- R8: `ch2_hiz` is 1 exactly while single mode is in effect, and 0 in the other three modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; both edges are used in double-edge mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_single | input | 1 | Mode pin: 1 selects single or broadcast, 0 selects split or double-edge |
| ddr_en | input | 1 | Second mode pin, selecting broadcast or double-edge |
| de | input | 1 | Data enable; sets the pairing phase in split mode |
| pix | input | PIX_W | Input pixel word |
| ch1_word | output | PIX_W | Word for channel 1 |
| ch2_word | output | PIX_W | Word for channel 2 |
| word_valid | output | 1 | Both channel words are new on this cycle |
| ch2_hiz | output | 1 | Channel 2 outputs are to be high impedance |
| de_err | output | 1 | One-cycle pulse: a line ended with an odd pixel count |

## Verification
On every cycle the assertions check several properties. Split mode never raises `word_valid` on two cycles in a row. Every error pulse is one cycle long, comes with a valid word and leaves channel 2 unchanged. The three non-split modes deliver a word on every cycle, and broadcast mode shows equal channel words. The mode register changes only after a DE-low sample. Only the bench scenarios can show that the right pixels arrive in the right order. These cover the pairing after each DE rise, the identity of the leftover pixel on odd lines, the rising/falling order in double-edge mode, and a mode change attempted in the middle of a line.

// File: rtl/dual_link_pixel_steer.sv
module dual_link_pixel_steer #(
  parameter int PIX_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_single,
  input  logic             ddr_en,
  input  logic             de,
  input  logic [PIX_W-1:0] pix,
  output logic [PIX_W-1:0] ch1_word,
  output logic [PIX_W-1:0] ch2_word,
  output logic             word_valid,
  output logic             ch2_hiz,
  output logic             de_err
);
  localparam logic [1:0] M_SPLIT  = 2'b00;
  localparam logic [1:0] M_DDR    = 2'b01;
  localparam logic [1:0] M_SINGLE = 2'b10;
  localparam logic [1:0] M_BCAST  = 2'b11;

  logic [1:0]       cfg_q;
  logic [PIX_W-1:0] fall_q, rise_q, hold_q;
  logic             de_q, odd_q;

  wire [1:0] cfg_in   = {mode_single, ddr_en};
  wire       de_rise  = de & ~de_q;
  wire       take_1st = de & (de_rise | ~odd_q);
  wire       take_2nd = de & ~take_1st;
  wire       orphan   = ~de & de_q & odd_q;

  assign ch2_hiz = (cfg_q == M_SINGLE);

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) fall_q <= '0;
    else        fall_q <= pix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= M_SINGLE;
      rise_q     <= '0;
      hold_q     <= '0;
      ch1_word   <= '0;
      ch2_word   <= '0;
      word_valid <= 1'b0;
      de_err     <= 1'b0;
      de_q       <= 1'b0;
      odd_q      <= 1'b0;
    end else begin
      rise_q     <= pix;
      de_q       <= de;
      word_valid <= 1'b0;
      de_err     <= 1'b0;
      case (cfg_q)
        M_SINGLE: begin
          ch1_word   <= pix;
          word_valid <= 1'b1;
        end
        M_BCAST: begin
          ch1_word   <= pix;
          ch2_word   <= pix;
          word_valid <= 1'b1;
        end
        M_DDR: begin
          ch1_word   <= rise_q;
          ch2_word   <= fall_q;
          word_valid <= 1'b1;
        end
        default: begin
          if (take_1st) begin
            hold_q <= pix;
            odd_q  <= 1'b1;
          end else if (take_2nd) begin
            ch1_word   <= hold_q;
            ch2_word   <= pix;
            word_valid <= 1'b1;
            odd_q      <= 1'b0;
          end else if (orphan) begin
            ch1_word   <= hold_q;
            word_valid <= 1'b1;
            de_err     <= 1'b1;
            odd_q      <= 1'b0;
          end
        end
      endcase
      if (!de) begin
        cfg_q <= cfg_in;
        if (cfg_in != cfg_q) odd_q <= 1'b0;
      end
    end
  end

  assert_split_alternate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == M_SPLIT && word_valid) |=> !word_valid);

  assert_orphan_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    de_err |-> (word_valid && !$past(de) && $stable(ch2_word)));

  assert_err_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    de_err |=> !de_err);

  assert_steady_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_q) != M_SPLIT) |-> word_valid);

  assert_bcast_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_q) == M_BCAST) |-> (ch1_word == ch2_word));

  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && cfg_q != $past(cfg_q)) |-> !$past(de));
endmodule

// File: tb/dual_link_pixel_steer_tb.sv
`timescale 1ns/1ps
module dual_link_pixel_steer_tb;
  localparam int W = 27;
  logic clk = 0, rst_n = 0, mode_single = 1, ddr_en = 0, de = 0;
  logic [W-1:0] pix = '0;
  logic [W-1:0] ch1_word, ch2_word;
  logic word_valid, ch2_hiz, de_err;
  int total = 0, bad = 0;

  dual_link_pixel_steer #(.PIX_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_single(mode_single), .ddr_en(ddr_en),
    .de(de), .pix(pix), .ch1_word(ch1_word), .ch2_word(ch2_word),
    .word_valid(word_valid), .ch2_hiz(ch2_hiz), .de_err(de_err));

  always #2 clk = ~clk;

  // reference state
  logic [1:0]   m_mode = 2'b10;
  logic         m_ph = 0, m_deq = 0;
  logic [W-1:0] m_hold = '0, m_rq = '0, m_ch2 = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // one pixel clock: fpx on the falling edge, rpx plus DE on the rising edge
  task automatic cycle(input logic [W-1:0] fpx, input logic [W-1:0] rpx,
                       input logic dv, input logic ms, input logic dd);
    logic [1:0] old_mode;
    logic ev, ee;
    logic [W-1:0] e1;
    string tag;
    pix = fpx; mode_single = ms; ddr_en = dd;
    #2;
    pix = rpx; de = dv;
    old_mode = m_mode; ev = 0; ee = 0; e1 = '0;
    case (m_mode)
      2'b10: begin ev = 1; e1 = rpx; tag = "R2"; end
      2'b11: begin ev = 1; e1 = rpx; m_ch2 = rpx; tag = "R5"; end
      2'b01: begin ev = 1; e1 = m_rq; m_ch2 = fpx; tag = "R6"; end
      default: begin
        tag = "R3";
        if (dv) begin
          if (!m_deq || !m_ph) begin m_hold = rpx; m_ph = 1; end
          else begin ev = 1; e1 = m_hold; m_ch2 = rpx; m_ph = 0; end
        end else if (m_deq && m_ph) begin
          ev = 1; ee = 1; e1 = m_hold; m_ph = 0; tag = "R4";
        end
      end
    endcase
    m_rq = rpx; m_deq = dv;
    if (!dv) begin
      if ({ms, dd} != m_mode) m_ph = 0;
      m_mode = {ms, dd};
    end
    @(posedge clk); #1;
    chk(word_valid === ev, tag, "word_valid", word_valid, ev);
    chk(de_err === ee, ee ? "R4" : tag, "de_err", de_err, ee);
    if (ev) chk(ch1_word === e1, tag, "ch1_word", ch1_word, e1);
    if (ev && old_mode != 2'b10)
      chk(ch2_word === m_ch2, tag, "ch2_word", ch2_word, m_ch2);
    chk(ch2_hiz === (m_mode == 2'b10), "R8", "ch2_hiz", ch2_hiz, m_mode == 2'b10);
  endtask

  function automatic logic [W-1:0] rnd_pix();
    return W'($urandom);
  endfunction

  task automatic rand_lines(input logic ms, input logic dd, input int n);
    for (int i = 0; i < 3; i++) cycle(rnd_pix(), rnd_pix(), 0, ms, dd);
    for (int l = 0; l < n; l++) begin
      int hi = 2 + int'($urandom % 9);
      int lo = 2 + int'($urandom % 4);
      for (int k = 0; k < hi; k++) cycle(rnd_pix(), rnd_pix(), 1, ms, dd);
      for (int k = 0; k < lo; k++) cycle(rnd_pix(), rnd_pix(), 0, ms, dd);
    end
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #7 rst_n = 1;
    #0.5;
    chk(word_valid === 1'b0, "R1", "word_valid after reset", word_valid, 0);
    chk(de_err === 1'b0, "R1", "de_err after reset", de_err, 0);
    chk(ch2_hiz === 1'b1, "R1", "ch2_hiz after reset", ch2_hiz, 1);

    // R2: single mode, DE toggling has no effect on delivery
    rand_lines(1, 0, 6);

    // R3 directed: even line of four, then R4: odd line of three
    for (int i = 0; i < 3; i++) cycle('0, '0, 0, 0, 0);
    cycle('0, 27'h0000A1, 1, 0, 0);
    cycle('0, 27'h0000A2, 1, 0, 0);
    cycle('0, 27'h0000A3, 1, 0, 0);
    cycle('0, 27'h0000A4, 1, 0, 0);
    cycle('0, 27'h0000B0, 0, 0, 0);
    cycle('0, 27'h0000B1, 0, 0, 0);
    cycle('0, 27'h0000C1, 1, 0, 0);
    cycle('0, 27'h0000C2, 1, 0, 0);
    cycle('0, 27'h0000C3, 1, 0, 0);
    cycle('0, 27'h0000D0, 0, 0, 0);
    cycle('0, 27'h0000D1, 0, 0, 0);
    // minimal line of one pixel: orphan with error pulse (R4)
    cycle('0, 27'h0000E1, 1, 0, 0);
    cycle('0, 27'h0000E2, 0, 0, 0);
    cycle('0, 27'h0000E3, 0, 0, 0);
    rand_lines(0, 0, 12);

    // R7: mode pin change in mid-line is ignored until DE is low
    cycle('0, 27'h0000F1, 1, 0, 0);
    cycle('0, 27'h0000F2, 1, 1, 0);
    chk(ch2_hiz === 1'b0, "R7", "ch2_hiz mid-line", ch2_hiz, 0);
    cycle('0, 27'h0000F3, 1, 1, 0);
    cycle('0, 27'h0000F4, 1, 1, 0);
    chk(ch2_hiz === 1'b0, "R7", "ch2_hiz end of line", ch2_hiz, 0);
    cycle('0, 27'h0000F5, 0, 1, 0);
    chk(ch2_hiz === 1'b1, "R7", "ch2_hiz after DE low", ch2_hiz, 1);

    // R5 broadcast, R6 double-edge, then back to split
    rand_lines(1, 1, 6);
    rand_lines(0, 1, 6);
    rand_lines(0, 0, 8);
    rand_lines(1, 0, 2);
    cycle('0, '0, 0, 1, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule